// File: doc/BRIEF.md
# Text-Mode Program Load Decoder

This block sits between a byte-wide serial receiver and a memory writer during boot. It watches the incoming characters for a space followed by one of two four-letter load keywords. `LDHX` selects hexadecimal text and `LDBS` selects 6-bit-per-character text. The data after the keyword is turned into a stream of binary bytes. Each byte is presented for one cycle with a valid strobe and a write address that counts up from zero.

A `~` character ends the load. The block then sends back a four-character status word through a valid/ready byte handshake towards a serial transmitter: `PASS` if the whole load was clean, `FAIL` otherwise. White space (space, tab, carriage return, line feed) may be placed anywhere in the data to split it into lines and tokens. The leading space matters to the sender because the receiver measures the baud rate on it.

Top module: `text_loader`

## Requirements
- R1: After reset, and until a space followed by a complete keyword has been received, the block makes no write and raises no transmit request. Characters that arrive while it waits for a space are ignored. `LDHX` (bytes 4C 44 48 58) selects hex mode and `LDBS` (4C 44 42 53) selects base64 mode.
- R2: The keyword is checked one character at a time. A wrong character abandons the attempt. If that character is a space, matching starts again from the first keyword letter. Any other wrong character sends the block back to waiting for a space.
- R3: In hex mode, a token of one or two hex digits (0-9, A-F, a-f) yields one byte. The first digit of a two-digit token is the upper nibble, and a single digit is the whole value (a lone `5` gives 0x05).
- R4: In hex mode, a token with a third digit is an error, and that token yields no byte.
- R5: In base64 mode, `A`-`Z` are 0-25, `a`-`z` are 26-51, `0`-`9` are 52-61, `+` is 62 and `/` is 63. The 6-bit values are packed first-received-most-significant. A byte is emitted whenever eight bits are complete, and bits still pending at `~` are dropped.
- R6: Space (0x20), tab (0x09), CR (0x0D) and LF (0x0A) are skipped in both modes. In hex mode they also end a token, and so does `~`.
- R7: The write address is 0 for the first byte after each accepted keyword and rises by one for each byte. `wr_valid` is high for exactly the cycle after the clock edge that accepts the character completing the byte.
- R8: A character that is illegal in the active mode is an error. After any error no further byte is written until the next accepted keyword.
- R9: On `~` (0x7E) the block offers `PASS` if no error occurred, otherwise `FAIL`, one character per accepted `tx_valid`/`tx_ready` handshake. `tx_data` is held steady while `tx_ready` is low.
- R10: While the status word is being sent, received characters are ignored. After the fourth character the block waits for a space again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| tx_ready | input | 1 | Transmitter takes `tx_data` this cycle when `tx_valid` is high |
| wr_valid | output | 1 | One-cycle strobe for a decoded byte |
| wr_addr | output | AW | Byte address of `wr_data` |
| wr_data | output | 8 | Decoded byte |
| tx_valid | output | 1 | A status character is offered |
| tx_data | output | 8 | Status character |

## Verification
Two things can happen in the same cycle. A `~` that directly follows the last hex digit completes that token's byte and also starts the status reply. The stimulus provokes this by placing `~` straight after a digit, with no white space between them, in both directed and random hex loads. The result is judged by the presence, value and address of the final byte together with a correct status word. A second overlap is characters arriving while a reply is held back by `tx_ready` low. The stimulus provokes it by stalling the transmitter and sending a full new command, which must leave no write and only one reply.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  localparam int KW_LEN  = 4;
  localparam int MSG_LEN = 4;

  localparam logic [8*KW_LEN-1:0]  KW_HEX_TXT = "LDHX";
  localparam logic [8*KW_LEN-1:0]  KW_B64_TXT = "LDBS";
  localparam logic [8*MSG_LEN-1:0] MSG_GOOD   = "PASS";
  localparam logic [8*MSG_LEN-1:0] MSG_BAD    = "FAIL";

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_TERM  = 8'h7E;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_KEY   = 2'd1,
    ST_DATA  = 2'd2,
    ST_REPLY = 2'd3
  } ldr_state_e;

  typedef struct packed {
    logic       emit;
    logic [7:0] data;
    logic [5:0] rest;
    logic [2:0] nbits;
  } b64_step_t;

  // character idx (0 = first) of the selected keyword
  function automatic logic [7:0] kw_char(input logic sel_b64, input int idx);
    return sel_b64 ? KW_B64_TXT[8*(KW_LEN-1-idx) +: 8]
                   : KW_HEX_TXT[8*(KW_LEN-1-idx) +: 8];
  endfunction

  function automatic logic [7:0] msg_char(input logic good, input int idx);
    return good ? MSG_GOOD[8*(MSG_LEN-1-idx) +: 8]
                : MSG_BAD[8*(MSG_LEN-1-idx) +: 8];
  endfunction

  function automatic logic is_blank(input logic [7:0] c);
    return (c == 8'h20) || (c == 8'h09) || (c == 8'h0D) || (c == 8'h0A);
  endfunction

  // {valid, nibble}
  function automatic logic [4:0] hex_digit(input logic [7:0] c);
    logic [4:0] r;
    r = '0;
    if (c >= 8'h30 && c <= 8'h39)      r = {1'b1, c[3:0]};
    else if (c >= 8'h41 && c <= 8'h46) r = {1'b1, 4'(c[3:0] + 4'd9)};
    else if (c >= 8'h61 && c <= 8'h66) r = {1'b1, 4'(c[3:0] + 4'd9)};
    return r;
  endfunction

  // {valid, six-bit value}
  function automatic logic [6:0] b64_digit(input logic [7:0] c);
    logic [6:0] r;
    r = '0;
    if (c >= 8'h41 && c <= 8'h5A)      r = {1'b1, 6'(c - 8'h41)};
    else if (c >= 8'h61 && c <= 8'h7A) r = {1'b1, 6'(c - 8'h47)};
    else if (c >= 8'h30 && c <= 8'h39) r = {1'b1, 6'(c + 8'h04)};
    else if (c == 8'h2B)               r = {1'b1, 6'd62};
    else if (c == 8'h2F)               r = {1'b1, 6'd63};
    return r;
  endfunction

  // append six bits to nbits pending bits (nbits is 0, 2, 4 or 6)
  function automatic b64_step_t b64_step(input logic [5:0] rest,
                                         input logic [2:0] nbits,
                                         input logic [5:0] v);
    b64_step_t  r;
    logic [11:0] joined;
    logic [2:0]  shift;
    logic [5:0]  mask;
    joined = {rest, v};
    shift  = nbits - 3'd2;
    mask   = 6'((7'd1 << shift) - 7'd1);
    if (nbits == 3'd0) begin
      r.emit  = 1'b0;
      r.data  = '0;
      r.rest  = v;
      r.nbits = 3'd6;
    end else begin
      r.emit  = 1'b1;
      r.data  = 8'(joined >> shift);
      r.rest  = joined[5:0] & mask;
      r.nbits = shift;
    end
    return r;
  endfunction

endpackage

// File: rtl/ldr_kw_match.sv
module ldr_kw_match
  import ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       step,
  input  logic [7:0] ch,
  output logic       hit_hex,
  output logic       hit_b64,
  output logic       miss
);
  localparam int IW = (KW_LEN > 1) ? $clog2(KW_LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(KW_LEN - 1);

  logic [IW-1:0] idx_q;
  logic          alive_hex_q, alive_b64_q;
  logic          eq_hex, eq_b64;

  assign eq_hex  = alive_hex_q && (ch == kw_char(1'b0, int'(idx_q)));
  assign eq_b64  = alive_b64_q && (ch == kw_char(1'b1, int'(idx_q)));
  assign hit_hex = step && eq_hex && (idx_q == LAST);
  assign hit_b64 = step && eq_b64 && (idx_q == LAST);
  assign miss    = step && !eq_hex && !eq_b64;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q       <= '0;
      alive_hex_q <= 1'b0;
      alive_b64_q <= 1'b0;
    end else if (restart) begin
      idx_q       <= '0;
      alive_hex_q <= 1'b1;
      alive_b64_q <= 1'b1;
    end else if (step) begin
      idx_q       <= idx_q + 1'b1;
      alive_hex_q <= eq_hex;
      alive_b64_q <= eq_b64;
    end
  end
endmodule

// File: rtl/ldr_data_decode.sv
module ldr_data_decode
  import ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       stb,
  input  logic [7:0] ch,
  input  logic       use_b64,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic       err,
  output logic       term_hit
);
  logic [7:0] hex_acc_q;
  logic [1:0] hex_cnt_q;
  logic [5:0] b64_rest_q;
  logic [2:0] b64_nb_q;
  logic       err_q;

  logic [4:0] dig_h;
  logic [6:0] dig_b;
  logic       blank, is_term, sep;
  logic       hex_hit, b64_hit, bad_char, over_long, err_now;
  logic       hex_emit, b64_emit;
  b64_step_t  pk;

  assign dig_h     = hex_digit(ch);
  assign dig_b     = b64_digit(ch);
  assign blank     = is_blank(ch);
  assign is_term   = (ch == CH_TERM);
  assign sep       = blank || is_term;
  assign hex_hit   = !use_b64 && dig_h[4];
  assign b64_hit   = use_b64 && dig_b[6];
  assign bad_char  = !sep && !hex_hit && !b64_hit;
  assign over_long = hex_hit && (hex_cnt_q == 2'd2);
  assign err_now   = stb && (bad_char || over_long);
  assign pk        = b64_step(b64_rest_q, b64_nb_q, dig_b[5:0]);
  assign hex_emit  = !use_b64 && sep && (hex_cnt_q != 2'd0);
  assign b64_emit  = b64_hit && pk.emit;

  assign byte_stb  = stb && !err_q && !err_now && (hex_emit || b64_emit);
  assign byte_val  = use_b64 ? pk.data : hex_acc_q;
  assign err       = err_q;
  assign term_hit  = stb && is_term;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hex_acc_q  <= '0;
      hex_cnt_q  <= '0;
      b64_rest_q <= '0;
      b64_nb_q   <= '0;
      err_q      <= 1'b0;
    end else if (stb) begin
      err_q <= err_q || err_now;
      if (!use_b64) begin
        if (sep) begin
          hex_acc_q <= '0;
          hex_cnt_q <= '0;
        end else if (hex_hit && !over_long) begin
          hex_acc_q <= {hex_acc_q[3:0], dig_h[3:0]};
          hex_cnt_q <= hex_cnt_q + 2'd1;
        end
      end
      if (b64_hit) begin
        b64_rest_q <= pk.rest;
        b64_nb_q   <= pk.nbits;
      end
    end
  end
endmodule

// File: rtl/ldr_status_tx.sv
module ldr_status_tx
  import ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       good,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       done
);
  localparam int IW = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(MSG_LEN - 1);

  logic          active_q, good_q;
  logic [IW-1:0] idx_q;

  assign tx_valid = active_q;
  assign tx_data  = msg_char(good_q, int'(idx_q));
  assign done     = active_q && tx_ready && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      good_q   <= 1'b0;
      idx_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      good_q   <= good;
      idx_q    <= '0;
    end else if (active_q && tx_ready) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/text_loader.sv
module text_loader
  import ldr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          tx_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data
);
  ldr_state_e    state_q, state_d;
  logic          mode_b64_q;
  logic [AW-1:0] next_addr_q;

  logic kw_restart, kw_step, hit_hex, hit_b64, kw_miss;
  logic dec_clear, dec_stb, byte_stb, dec_err, dec_term;
  logic [7:0] byte_val;
  logic tx_start, tx_done, got_space;

  assign got_space = rx_valid && (rx_data == CH_SPACE);
  assign kw_step   = rx_valid && (state_q == ST_KEY);
  assign dec_stb   = rx_valid && (state_q == ST_DATA);
  assign dec_clear = hit_hex || hit_b64;

  ldr_kw_match u_kw (
    .clk(clk), .rst_n(rst_n), .restart(kw_restart), .step(kw_step),
    .ch(rx_data), .hit_hex(hit_hex), .hit_b64(hit_b64), .miss(kw_miss)
  );

  ldr_data_decode u_dec (
    .clk(clk), .rst_n(rst_n), .clear(dec_clear), .stb(dec_stb),
    .ch(rx_data), .use_b64(mode_b64_q), .byte_stb(byte_stb),
    .byte_val(byte_val), .err(dec_err), .term_hit(dec_term)
  );

  ldr_status_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .good(!dec_err),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .done(tx_done)
  );

  always_comb begin
    state_d    = state_q;
    kw_restart = 1'b0;
    tx_start   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (got_space) begin
          kw_restart = 1'b1;
          state_d    = ST_KEY;
        end
      end
      ST_KEY: begin
        if (hit_hex || hit_b64) begin
          state_d = ST_DATA;
        end else if (kw_miss) begin
          if (got_space) kw_restart = 1'b1;
          else           state_d    = ST_IDLE;
        end
      end
      ST_DATA: begin
        if (dec_term) begin
          tx_start = 1'b1;
          state_d  = ST_REPLY;
        end
      end
      ST_REPLY: begin
        if (tx_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_b64_q  <= 1'b0;
      next_addr_q <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      state_q  <= state_d;
      wr_valid <= byte_stb;
      if (dec_clear) begin
        mode_b64_q  <= hit_b64;
        next_addr_q <= '0;
      end else if (byte_stb) begin
        next_addr_q <= next_addr_q + 1'b1;
        wr_addr     <= next_addr_q;
        wr_data     <= byte_val;
      end
    end
  end
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker
  import ldr_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    state,
  input logic          byte_stb,
  input logic          dec_err,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] next_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data
);
  assert_write_in_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> state == ST_DATA);

  assert_addr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> wr_valid && wr_addr == $past(next_addr));

  assert_no_write_after_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> !byte_stb);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_tx_in_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> state == ST_REPLY);

  assert_reply_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_REPLY && $past(state) == ST_REPLY |-> !wr_valid);
endmodule

bind text_loader ldr_checker #(.AW(AW)) u_ldr_checker (
  .clk(clk), .rst_n(rst_n), .state(state_q), .byte_stb(byte_stb),
  .dec_err(dec_err), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .next_addr(next_addr_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data)
);

// File: tb/test_text_loader.sv
module test_text_loader;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          tx_ready = 1'b0;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          tx_valid;
  logic [7:0]    tx_data;

  text_loader #(.AW(AW)) i_text_loader (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit hold_ready = 1'b0;
  logic [7:0] got_d[$];
  int         got_a[$];
  logic [7:0] rep_q[$];
  logic [7:0] exp_q[$];
  bit         exp_pass;

  always @(posedge clk) tx_ready <= hold_ready ? 1'b0 : ($urandom % 4 != 0);

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        got_d.push_back(wr_data);
        got_a.push_back(int'(wr_addr));
      end
      if (tx_valid && tx_ready) rep_q.push_back(tx_data);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic send_text(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_obs();
    got_d.delete();
    got_a.delete();
    rep_q.delete();
  endtask

  task automatic wait_reply();
    for (int i = 0; i < 400 && rep_q.size() < 4; i++) @(negedge clk);
  endtask

  function automatic int hexv(input logic [7:0] c);
    if (c >= "0" && c <= "9") return int'(c) - 48;
    if (c >= "a" && c <= "f") return int'(c) - 87;
    if (c >= "A" && c <= "F") return int'(c) - 55;
    return -1;
  endfunction

  function automatic int b64v(input logic [7:0] c);
    string alpha;
    alpha = "ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqrstuvwxyz0123456789+/";
    for (int i = 0; i < 64; i++) if (alpha[i] == c) return i;
    return -1;
  endfunction

  function automatic bit blank(input logic [7:0] c);
    return c == " " || c == "\t" || c == "\r" || c == "\n";
  endfunction

  // expected bytes and status for the data between keyword and terminator
  function automatic void model(input bit b64, input string d);
    exp_q.delete();
    exp_pass = 1'b1;
    if (!b64) begin
      int tl = 0;
      int tv = 0;
      bit bad = 1'b0;
      for (int i = 0; i <= d.len(); i++) begin
        logic [7:0] c;
        c = (i == d.len()) ? 8'h20 : d[i];
        if (blank(c)) begin
          if (tl > 0 && exp_pass) begin
            if (bad || tl > 2) exp_pass = 1'b0;
            else exp_q.push_back(8'(tv));
          end
          tl = 0; tv = 0; bad = 1'b0;
        end else begin
          tl++;
          if (hexv(c) < 0) bad = 1'b1;
          else tv = tv * 16 + hexv(c);
        end
      end
    end else begin
      int acc = 0;
      int bits = 0;
      for (int i = 0; i < d.len(); i++) begin
        if (!blank(d[i])) begin
          if (b64v(d[i]) < 0) begin
            exp_pass = 1'b0;
            break;
          end
          acc  = acc * 64 + b64v(d[i]);
          bits = bits + 6;
          if (bits >= 8) begin
            exp_q.push_back(8'((acc >> (bits - 8)) & 255));
            bits = bits - 8;
            acc  = acc & ((1 << bits) - 1);
          end
        end
      end
    end
  endfunction

  task automatic judge(input string req_data);
    logic [31:0] got_w, exp_w;
    int n;
    check(got_d.size() == exp_q.size(), "R7", "byte count", got_d.size(), exp_q.size());
    n = (got_d.size() < exp_q.size()) ? got_d.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      check(got_d[i] == exp_q[i], req_data, "byte value", int'(got_d[i]), int'(exp_q[i]));
      check(got_a[i] == i, "R7", "byte address", got_a[i], i);
    end
    got_w = '0;
    for (int i = 0; i < rep_q.size() && i < 4; i++) got_w = {got_w[23:0], rep_q[i]};
    exp_w = exp_pass ? "PASS" : "FAIL";
    check(rep_q.size() == 4 && got_w == exp_w, "R9", "status word", int'(got_w), int'(exp_w));
  endtask

  task automatic session(input bit b64, input string d, input string req);
    string kw;
    kw = b64 ? "LDBS" : "LDHX";
    clear_obs();
    send_text({" ", kw, d, "~"});
    wait_reply();
    model(b64, d);
    judge(req);
  endtask

  function automatic string one_char(input logic [7:0] c);
    string t;
    t = " ";
    t[0] = c;
    return t;
  endfunction

  function automatic string rand_blank();
    string ws;
    ws = " \t\r\n";
    return one_char(ws[$urandom % 4]);
  endfunction

  function automatic string rand_hex(input int ntok);
    string s, digs;
    digs = "0123456789abcdefABCDEF";
    s = "";
    for (int t = 0; t < ntok; t++) begin
      s = {s, rand_blank()};
      if ($urandom % 3 == 0) s = {s, rand_blank()};
      for (int k = 0; k < 1 + int'($urandom % 2); k++) s = {s, one_char(digs[$urandom % 22])};
    end
    return s;
  endfunction

  function automatic string rand_b64(input int nch);
    string s, alpha;
    alpha = "ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqrstuvwxyz0123456789+/";
    s = "";
    for (int k = 0; k < nch; k++) begin
      if ($urandom % 4 == 0) s = {s, rand_blank()};
      s = {s, one_char(alpha[$urandom % 64])};
    end
    return s;
  endfunction

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);
    check(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);

    // R1: no leading space, nothing happens
    clear_obs();
    send_text("xyLDHX 12~");
    repeat (30) @(negedge clk);
    check(got_d.size() == 0 && rep_q.size() == 0, "R1", "activity without space",
          got_d.size() + rep_q.size(), 0);

    // R2: wrong keyword letter abandons the attempt
    clear_obs();
    send_text(" LDQX 12~");
    repeat (30) @(negedge clk);
    check(got_d.size() == 0 && rep_q.size() == 0, "R2", "activity after bad keyword",
          got_d.size() + rep_q.size(), 0);

    // R2: space inside the keyword restarts matching
    clear_obs();
    send_text(" LD LDHX 07~");
    wait_reply();
    model(1'b0, " 07");
    judge("R2");

    // R3 / R6: hex with every blank kind; '~' directly after a digit
    session(1'b0, " 0 0 0 0 FB F7\t23 f6\r\n25  26", "R3");
    session(1'b0, "\n5 a B\tc0 Ff 9", "R6");
    // R4: three-digit token
    session(1'b0, " 12 345 67", "R4");
    // R8: illegal characters
    session(1'b0, " 12 G5 34", "R8");
    session(1'b1, " QUJD*QUJD", "R8");
    // R5: packing and leftover bits
    session(1'b1, " QQ", "R5");
    session(1'b1, " +/cj9v37I/YlJoD/KIBm/fD/n/0", "R5");
    session(1'b1, "\r\nAAAA //// zz", "R6");

    // R10: a full command during a stalled reply is ignored
    hold_ready = 1'b1;
    clear_obs();
    send_text(" LDHX 21~");
    repeat (2) @(negedge clk);
    clear_obs();
    send_text(" LDHX 5~");
    check(got_d.size() == 0, "R10", "writes during reply", got_d.size(), 0);
    hold_ready = 1'b0;
    wait_reply();
    check(rep_q.size() == 4 && rep_q[0] == "P", "R10", "reply after stall",
          rep_q.size(), 4);
    repeat (60) @(negedge clk);
    check(rep_q.size() == 4 && got_d.size() == 0, "R10", "second reply or write",
          rep_q.size() + got_d.size(), 4);

    // random loads
    for (int n = 0; n < 8; n++) session(1'b0, rand_hex(3 + int'($urandom % 10)), "R3");
    for (int n = 0; n < 8; n++) session(1'b1, rand_b64(2 + int'($urandom % 30)), "R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule